// File: doc/BRIEF.md
# Byte-Oriented Execute Unit with Skip

This block is the execute stage of a small 8-bit accumulator processor. Each issued instruction carries an opcode, a file-register address, a destination-select bit, a bit index and an 8-bit literal. The unit reads the addressed entry of its internal register file and computes a result. Depending on the opcode and the destination bit, it writes that result to the working register (W) or back into the file entry. It updates the zero flag only for the opcodes defined to touch it.

Conditional opcodes raise a registered skip request. While that request is pending, the next issued instruction is turned into a no-op: it writes nothing and then clears the request. In effect, a taken skip costs the skipping instruction a second cycle. A combinational read port lets the surrounding pipeline, or a bench, inspect any file entry.

Top module: `byte_exec_unit`

## Requirements
- R1: After reset, W reads 00h, the zero flag reads 0, skip_pending reads 0, and every file entry reads 00h.
- R2: Opcode codes on `op_code` are: 0 no-op, 1 complement, 2 decrement, 3 increment, 4 OR W into file, 5 decrement-skip-if-zero, 6 increment-skip-if-zero, 7 clear file, 8 clear W, 9 OR literal into W, 10 bit-test-skip-if-set. Codes 11 to 15 behave as no-op.
- R3: For codes 1 to 6, `dest_file` = 0 writes the result to W and leaves the file entry unchanged. `dest_file` = 1 writes the result to the entry at `faddr` and leaves W unchanged.
- R4: Complement gives ~f, decrement gives f-1 (00h wraps to FFh), increment gives f+1 (FFh wraps to 00h), and OR-into-file gives W|f. Each sets the zero flag exactly when its 8-bit result is 00h.
- R5: Decrement-skip and increment-skip produce the same result and routing as the plain forms. They leave the zero flag unchanged, and they set skip_pending exactly when the result is 00h.
- R6: Clear-file writes 00h to the addressed entry and clear-W writes 00h to W. Both set the zero flag to 1.
- R7: OR-literal writes W|`literal` to W and sets the zero flag exactly when that value is 00h.
- R8: Bit-test-skip sets skip_pending exactly when bit `bit_sel` of the addressed entry is 1. It writes neither W, the file nor the zero flag.
- R9: While skip_pending is 1, the next cycle with `issue` high writes nothing to W, the file or the zero flag, and clears skip_pending. Cycles with `issue` low leave skip_pending unchanged.
- R10: A cycle with `issue` low changes no W, zero flag or file state.
- R11: `peek_data` shows the current contents of the file entry at `peek_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An instruction is presented this cycle |
| op_code | input | 4 | Opcode (encoding in R2) |
| faddr | input | 7 | File-register address |
| dest_file | input | 1 | 0 routes result to W, 1 to the file entry |
| bit_sel | input | 3 | Bit index for bit-test-skip |
| literal | input | 8 | Literal operand |
| peek_addr | input | 7 | Read address for inspection |
| peek_data | output | 8 | Contents of entry at peek_addr |
| w_out | output | 8 | Working register |
| zflag | output | 1 | Zero flag |
| skip_pending | output | 1 | Next issued instruction will be squashed |

## Verification
Two functions can fall in the same cycle. The first is the squash of a pending skip. The second is the arrival of another skip-capable instruction whose own condition holds. The squashed instruction must neither write nor re-arm the skip. The bench provokes this with back-to-back skip opcodes on a zero-wrapping counter and on set bits, both directed and inside a random stream that uses only eight addresses so collisions are frequent. A bench model judges W, the zero flag, skip_pending and the touched entry after every cycle.

// File: rtl/byte_exec_pkg.sv
package byte_exec_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_COMP   = 4'd1,
    OP_DEC    = 4'd2,
    OP_INC    = 4'd3,
    OP_ORWF   = 4'd4,
    OP_DECSKZ = 4'd5,
    OP_INCSKZ = 4'd6,
    OP_CLRF   = 4'd7,
    OP_CLRW   = 4'd8,
    OP_ORLIT  = 4'd9,
    OP_BTSKS  = 4'd10
  } op_e;

  typedef struct packed {
    logic wr_w;
    logic wr_f;
    logic z_upd;
    logic skip;
  } ctl_t;
endpackage

// File: rtl/exec_regfile.sv
module exec_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import byte_exec_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic [3:0]        op_code,
  input  logic              dest_file,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic [DATA_W-1:0] fval,
  input  logic [DATA_W-1:0] wval,
  input  logic [DATA_W-1:0] lit,
  output logic [DATA_W-1:0] result,
  output ctl_t              ctl
);
  op_e op;
  logic res_zero;

  assign op       = op_e'(op_code);
  assign res_zero = (result == '0);

  always_comb begin
    result = '0;
    ctl    = '0;
    unique case (op)
      OP_COMP, OP_DEC, OP_INC, OP_ORWF, OP_DECSKZ, OP_INCSKZ: begin
        case (op)
          OP_COMP:             result = ~fval;
          OP_DEC, OP_DECSKZ:   result = fval - 1'b1;
          OP_INC, OP_INCSKZ:   result = fval + 1'b1;
          default:             result = wval | fval;
        endcase
        ctl.wr_w = ~dest_file;
        ctl.wr_f = dest_file;
        if (op == OP_DECSKZ || op == OP_INCSKZ) ctl.skip  = res_zero;
        else                                    ctl.z_upd = 1'b1;
      end
      OP_CLRF: begin
        ctl.wr_f  = 1'b1;
        ctl.z_upd = 1'b1;
      end
      OP_CLRW: begin
        ctl.wr_w  = 1'b1;
        ctl.z_upd = 1'b1;
      end
      OP_ORLIT: begin
        result    = wval | lit;
        ctl.wr_w  = 1'b1;
        ctl.z_upd = 1'b1;
      end
      OP_BTSKS: ctl.skip = fval[bit_sel];
      default: ;
    endcase
  end
endmodule

// File: rtl/byte_exec_unit.sv
module byte_exec_unit
  import byte_exec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [3:0]        op_code,
  input  logic [ADDR_W-1:0] faddr,
  input  logic              dest_file,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic [DATA_W-1:0] literal,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [DATA_W-1:0] peek_data,
  output logic [DATA_W-1:0] w_out,
  output logic              zflag,
  output logic              skip_pending
);
  logic [DATA_W-1:0] w_q, w_d, fval, result;
  logic              z_q, z_d, skip_q, skip_d, live, f_we;
  ctl_t              ctl;

  exec_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(f_we), .waddr(faddr), .wdata(result),
    .raddr_a(faddr), .rdata_a(fval), .raddr_b(peek_addr), .rdata_b(peek_data)
  );

  exec_alu #(.DATA_W(DATA_W)) u_alu (
    .op_code(op_code), .dest_file(dest_file), .bit_sel(bit_sel),
    .fval(fval), .wval(w_q), .lit(literal), .result(result), .ctl(ctl)
  );

  // an instruction only takes effect when issued and not being squashed
  assign live = issue & ~skip_q;
  assign f_we = live & ctl.wr_f;

  always_comb begin
    w_d    = w_q;
    z_d    = z_q;
    skip_d = skip_q;
    if (live && ctl.wr_w)  w_d = result;
    if (live && ctl.z_upd) z_d = (result == '0);
    if (issue)             skip_d = live & ctl.skip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q    <= '0;
      z_q    <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      w_q    <= w_d;
      z_q    <= z_d;
      skip_q <= skip_d;
    end
  end

  assign w_out        = w_q;
  assign zflag        = z_q;
  assign skip_pending = skip_q;
endmodule

// File: rtl/byte_exec_checker.sv
module byte_exec_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue,
  input logic [3:0]        op_code,
  input logic [DATA_W-1:0] literal,
  input logic [DATA_W-1:0] w_out,
  input logic              zflag,
  input logic              skip_pending
);
  logic live;
  assign live = issue & ~skip_pending;

  // R9: a squashed instruction clears the pending skip
  a_r9_skip_clears: assert property (@(posedge clk) disable iff (!rst_n)
    issue && skip_pending |=> !skip_pending);

  // R9: a squashed instruction leaves W and the zero flag alone
  a_r9_squash_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    issue && skip_pending |=> $stable(w_out) && $stable(zflag));

  // R9 / R10: idle cycles hold all visible state
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(w_out) && $stable(zflag) && $stable(skip_pending));

  // R5 / R8: skip opcodes never touch the zero flag
  a_r5_skip_ops_keep_z: assert property (@(posedge clk) disable iff (!rst_n)
    live && (op_code == 4'd5 || op_code == 4'd6 || op_code == 4'd10) |=> $stable(zflag));

  // R6: clears set the zero flag
  a_r6_clear_sets_z: assert property (@(posedge clk) disable iff (!rst_n)
    live && (op_code == 4'd7 || op_code == 4'd8) |=> zflag);

  // R7: OR-literal result and flag
  a_r7_or_literal: assert property (@(posedge clk) disable iff (!rst_n)
    live && op_code == 4'd9 |=>
      (w_out == ($past(w_out) | $past(literal))) && (zflag == (w_out == '0)));

  // R8: bit test never writes W
  a_r8_btest_no_w: assert property (@(posedge clk) disable iff (!rst_n)
    live && op_code == 4'd10 |=> $stable(w_out));
endmodule

bind byte_exec_unit byte_exec_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .op_code(op_code), .literal(literal),
  .w_out(w_out), .zflag(zflag), .skip_pending(skip_pending)
);

// File: tb/test_byte_exec_unit.sv
module test_byte_exec_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue = 1'b0;
  logic [3:0] op_code = '0;
  logic [6:0] faddr = '0;
  logic       dest_file = 1'b0;
  logic [2:0] bit_sel = '0;
  logic [7:0] literal = '0;
  logic [6:0] peek_addr = '0;
  logic [7:0] peek_data, w_out;
  logic       zflag, skip_pending;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  logic [7:0] m_mem [128];
  logic [7:0] m_w;
  logic       m_z, m_sp;

  always #5 clk = ~clk;

  byte_exec_unit i_byte_exec_unit (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op_code(op_code), .faddr(faddr),
    .dest_file(dest_file), .bit_sel(bit_sel), .literal(literal),
    .peek_addr(peek_addr), .peek_data(peek_data), .w_out(w_out),
    .zflag(zflag), .skip_pending(skip_pending)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd1, 4'd2, 4'd3, 4'd4: return "R4";
      4'd5, 4'd6:             return "R5";
      4'd7, 4'd8:             return "R6";
      4'd9:                   return "R7";
      4'd10:                  return "R8";
      default:                return "R2";
    endcase
  endfunction

  // model step from the requirements
  task automatic model(logic [3:0] op, logic [6:0] a, logic d, logic [2:0] b, logic [7:0] k);
    logic [7:0] f, r;
    f = m_mem[a];
    if (m_sp) begin
      m_sp = 1'b0;
      return;
    end
    case (op)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: begin
        r = (op == 4'd1) ? ~f :
            (op == 4'd2 || op == 4'd5) ? f - 8'd1 :
            (op == 4'd3 || op == 4'd6) ? f + 8'd1 : (m_w | f);
        if (d) m_mem[a] = r; else m_w = r;
        if (op >= 4'd5) m_sp = (r == 8'h00);
        else            m_z  = (r == 8'h00);
      end
      4'd7: begin m_mem[a] = 8'h00; m_z = 1'b1; end
      4'd8: begin m_w = 8'h00; m_z = 1'b1; end
      4'd9: begin m_w = m_w | k; m_z = (m_w == 8'h00); end
      4'd10: m_sp = f[b];
      default: ;
    endcase
  endtask

  task automatic do_op(logic [3:0] op, logic [6:0] a, logic d, logic [2:0] b, logic [7:0] k);
    string rq;
    logic was_sp;
    was_sp = m_sp;
    rq = was_sp ? "R9" : req_of(op);
    issue = 1'b1; op_code = op; faddr = a; dest_file = d; bit_sel = b; literal = k;
    peek_addr = a;
    model(op, a, d, b, k);
    @(negedge clk);
    issue = 1'b0;
    check(rq, "w_out", w_out, m_w);
    check(rq, "zflag", {7'd0, zflag}, {7'd0, m_z});
    check(rq, "skip_pending", {7'd0, skip_pending}, {7'd0, m_sp});
    check(d ? "R3" : rq, "file entry", peek_data, m_mem[a]);
  endtask

  // load an entry with a value through the instruction set
  task automatic load(logic [6:0] a, logic [7:0] v);
    do_op(4'd7, a, 1'b1, 3'd0, 8'h00);
    do_op(4'd8, a, 1'b0, 3'd0, 8'h00);
    do_op(4'd9, a, 1'b0, 3'd0, v);
    do_op(4'd4, a, 1'b1, 3'd0, 8'h00);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
    m_w = 8'h00; m_z = 1'b0; m_sp = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "w_out", w_out, 8'h00);
    check("R1", "zflag", {7'd0, zflag}, 8'h00);
    check("R1", "skip_pending", {7'd0, skip_pending}, 8'h00);
    for (int i = 0; i < 128; i += 37) begin
      peek_addr = 7'(i);
      #1 check("R1", "entry", peek_data, 8'h00);
    end

    // R11 peek shows a fresh write at once
    load(7'd20, 8'hA5);
    peek_addr = 7'd20;
    #1 check("R11", "peek", peek_data, 8'hA5);

    // R4 wraps and R3 routing
    do_op(4'd7, 7'd3, 1'b1, 3'd0, 8'h00);
    do_op(4'd2, 7'd3, 1'b1, 3'd0, 8'h00);   // 00 -> FF in file
    do_op(4'd3, 7'd3, 1'b0, 3'd0, 8'h00);   // W = 00, Z = 1
    do_op(4'd1, 7'd3, 1'b0, 3'd0, 8'h00);   // W = 00, Z = 1

    // R5 increment-skip wraps to zero, then R9 squash of an OR-literal
    do_op(4'd6, 7'd3, 1'b1, 3'd0, 8'h00);
    do_op(4'd9, 7'd3, 1'b0, 3'd0, 8'h55);
    // back-to-back skip: squashed skip op must not re-arm (R9)
    load(7'd5, 8'h01);
    do_op(4'd5, 7'd5, 1'b1, 3'd0, 8'h00);   // 01 -> 00, skip
    do_op(4'd10, 7'd20, 1'b0, 3'd0, 8'h00); // bit 0 of A5 set, but squashed
    // R9 pending skip survives idle cycles
    do_op(4'd10, 7'd20, 1'b0, 3'd2, 8'h00); // bit 2 of A5 set
    repeat (3) @(negedge clk);
    check("R9", "held skip", {7'd0, skip_pending}, 8'h01);
    check("R10", "idle w", w_out, m_w);
    do_op(4'd8, 7'd0, 1'b0, 3'd0, 8'h00);   // squashed clear-W
    do_op(4'd10, 7'd20, 1'b0, 3'd1, 8'h00); // bit 1 clear, no skip

    // constrained random mix over a small address window
    for (int n = 0; n < 1500; n++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      if (n % 4 == 0) op = 4'($urandom_range(5, 6));
      do_op(op, 7'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
            3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)));
      if ($urandom_range(0, 9) == 0) begin
        @(negedge clk);
        check("R10", "idle w", w_out, m_w);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule